// File: doc/BRIEF.md
# Processor Cluster Boot-Vector and Power-Request Control

This block is a small register file sitting on a 32-bit register bus in front of a four-core processor cluster. For every core it keeps a 64-bit boot address, held as two 32-bit words, and presents the joined value on a wide output so each core fetches from it on its next reset. It also keeps one power-down request bit per core, which is driven straight out as that core's power-status line.

Each core reports that it is idling in wait-for-interrupt through a level input. The block captures that level and forwards it toward the power management unit only while software has requested power-down for the same core, so a core that merely waits for an interrupt is never mistaken for one that may be switched off. A handful of plain configuration words (two general config words, a coherency-control word, a snoop-control word and a status word with read-only bits) complete the map.

Accesses count only when all four byte strobes are set. Read data is registered and appears one cycle after the read request. A read of an unmapped offset returns zero.

Top module: `core_cluster_ctrl`

## Requirements
- R1: After reset, registers read as: 0x18 = 0x00000F0F, 0x1C = 0, 0x60 = 0x000F000F, 0x80 = 0, 0x90 = 0, 0x94 = 0, every boot low word = 0xFFFF0000 and every boot high word = 0. Each `rst_vec_o` slice is then 0x00000000_FFFF0000, and `pwr_stat_o`, `wfi_out` and `bus_rdata` are 0.
- R2: With all strobes set, a write to 0x18, 0x1C, 0x60 or 0x80 stores all 32 bits, and a later read returns them.
- R3: Core i has its boot low word at 0x40 + 8*i and its high word at 0x44 + 8*i. `rst_vec_o[64*i +: 64]` equals high*2^32 + low, and it takes a new value on the cycle after a write to either word.
- R4: Bit i of the power-control register at 0x90 is core i's power-down request. `pwr_stat_o[i]` equals that bit, and it changes on the cycle after the write that changes it.
- R5: `wfi_in` is captured on every clock. `wfi_out[i]` is high exactly when the captured `wfi_in[i]` and power-down request bit i are both high, so it follows `wfi_in` with one cycle of latency.
- R6: A write or read whose `bus_be` is not 4'b1111 is ignored. No register changes, and `bus_rdata` is 0 on the following cycle.
- R7: In the status word at 0x94, bits 0-3 and 16-17 are read-only and read as 0. All other bits are stored as written.
- R8: A read of an offset not listed in R1 or R3 returns 0. A write to such an offset changes no register.
- R9: `bus_rdata` holds the value of the addressed register the cycle after an accepted read, and is 0 after any cycle without one. When a read and a write hit the same offset in one cycle, the read returns the old value.
- R10: Bits 31:4 of the power-control register ignore writes and read as 0.
- R11: Asserting reset at any time returns every register and output to its R1 value, including clearing the captured `wfi_in` state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 8 | Byte offset of the access |
| bus_be | input | 4 | Byte strobes; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wfi_in | input | 4 | Per-core wait-for-interrupt level |
| wfi_out | output | 4 | Per-core gated wait-for-interrupt toward power management |
| pwr_stat_o | output | 4 | Per-core power-down request status |
| rst_vec_o | output | 256 | Per-core 64-bit boot address, core i at bits 64*i+63:64*i |

## Verification
The assertions check on every cycle that the WFI gate equals the request bits ANDed with the previous cycle's WFI inputs, that a full-strobe write to any boot word or to the power-control word shows up on the outputs one cycle later, that a partial-strobe write leaves those outputs frozen, and that read data is zero after any cycle without an accepted read. Only the bench's scenarios can show the register-map properties: reset values seen through reads, storage of the read-only mask on the status word, unmapped offsets reading zero and absorbing writes, read-before-write ordering on the same offset, and a reset in mid-run that clears captured WFI state.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int DW = 32;

  // Register offsets (byte addresses)
  localparam logic [31:0] OFF_CFG0  = 32'h18;
  localparam logic [31:0] OFF_CFG1  = 32'h1C;
  localparam logic [31:0] OFF_VEC   = 32'h40;
  localparam logic [31:0] OFF_COH   = 32'h60;
  localparam logic [31:0] OFF_SNOOP = 32'h80;
  localparam logic [31:0] OFF_PCTL  = 32'h90;
  localparam logic [31:0] OFF_PSTAT = 32'h94;

  localparam int VEC_STRIDE = 8;
  localparam int VEC_HI_OFS = 4;

  // Reset values and masks
  localparam logic [31:0] RST_CFG0   = 32'h0000_0F0F;
  localparam logic [31:0] RST_COH    = 32'h000F_000F;
  localparam logic [31:0] RST_VEC_LO = 32'hFFFF_0000;
  localparam logic [31:0] PSTAT_RO   = 32'h0003_000F;

  // Boot address = high word shifted up by 32 plus low word
  function automatic logic [63:0] join_vec(input logic [31:0] hi, input logic [31:0] lo);
    return ({32'b0, hi} << 32) + {32'b0, lo};
  endfunction

  // Merge a write into a word that has read-only bits
  function automatic logic [31:0] keep_ro(input logic [31:0] old_v,
                                          input logic [31:0] new_v,
                                          input logic [31:0] ro_mask);
    return (old_v & ro_mask) | (new_v & ~ro_mask);
  endfunction

  // Byte offset of core idx's boot word (hi selects the upper word)
  function automatic logic [31:0] vec_off(input int idx, input bit hi);
    return OFF_VEC + 32'(idx * VEC_STRIDE) + (hi ? 32'(VEC_HI_OFS) : 32'd0);
  endfunction

endpackage

// File: rtl/cc_bus_qual.sv
module cc_bus_qual #(
  parameter int BE_W = 4
) (
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [BE_W-1:0] bus_be,
  output logic            wr_acc,
  output logic            rd_acc,
  output logic            wr_part
);
  logic full_be;

  always_comb begin
    full_be = &bus_be;
    wr_acc  = bus_wr & full_be;
    rd_acc  = bus_rd & full_be;
    wr_part = bus_wr & ~full_be;
  end
endmodule

// File: rtl/cc_regfile.sv
module cc_regfile
  import cc_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_acc,
  input  logic                        rd_acc,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic [NCORES-1:0][DW-1:0]   vec_lo,
  output logic [NCORES-1:0][DW-1:0]   vec_hi,
  output logic [NCORES-1:0]           pwr_req
);
  localparam int PAD_W = DW - NCORES;

  logic [DW-1:0] cfg0_q, cfg1_q, coh_q, snoop_q, pstat_q;
  logic [DW-1:0] rd_val;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [31:0] off);
    return a == ADDR_W'(off);
  endfunction

  // Scalar words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q  <= RST_CFG0;
      cfg1_q  <= '0;
      coh_q   <= RST_COH;
      snoop_q <= '0;
      pstat_q <= '0;
      pwr_req <= '0;
    end else if (wr_acc) begin
      if (hit(addr, OFF_CFG0))  cfg0_q  <= wdata;
      if (hit(addr, OFF_CFG1))  cfg1_q  <= wdata;
      if (hit(addr, OFF_COH))   coh_q   <= wdata;
      if (hit(addr, OFF_SNOOP)) snoop_q <= wdata;
      if (hit(addr, OFF_PSTAT)) pstat_q <= keep_ro(pstat_q, wdata, PSTAT_RO);
      if (hit(addr, OFF_PCTL))  pwr_req <= wdata[NCORES-1:0];
    end
  end

  // Per-core boot words
  for (genvar g = 0; g < NCORES; g++) begin : g_vec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_lo[g] <= RST_VEC_LO;
        vec_hi[g] <= '0;
      end else if (wr_acc) begin
        if (hit(addr, vec_off(g, 1'b0))) vec_lo[g] <= wdata;
        if (hit(addr, vec_off(g, 1'b1))) vec_hi[g] <= wdata;
      end
    end
  end

  // Read decode
  always_comb begin
    rd_val = '0;
    if (hit(addr, OFF_CFG0))  rd_val = cfg0_q;
    if (hit(addr, OFF_CFG1))  rd_val = cfg1_q;
    if (hit(addr, OFF_COH))   rd_val = coh_q;
    if (hit(addr, OFF_SNOOP)) rd_val = snoop_q;
    if (hit(addr, OFF_PSTAT)) rd_val = pstat_q;
    if (hit(addr, OFF_PCTL))  rd_val = {{PAD_W{1'b0}}, pwr_req};
    for (int i = 0; i < NCORES; i++) begin
      if (hit(addr, vec_off(i, 1'b0))) rd_val = vec_lo[i];
      if (hit(addr, vec_off(i, 1'b1))) rd_val = vec_hi[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_acc) rdata <= rd_val;
    else             rdata <= '0;
  end
endmodule

// File: rtl/cc_core_slice.sv
module cc_core_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_lvl,
  input  logic pdn_req,
  output logic wfi_gated
);
  logic wfi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wfi_q <= 1'b0;
    else        wfi_q <= wfi_lvl;
  end

  always_comb wfi_gated = wfi_q & pdn_req;
endmodule

// File: rtl/core_cluster_ctrl.sv
module core_cluster_ctrl
  import cc_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCORES-1:0]    wfi_in,
  output logic [NCORES-1:0]    wfi_out,
  output logic [NCORES-1:0]    pwr_stat_o,
  output logic [NCORES*64-1:0] rst_vec_o
);
  // Named internal events (used by the bound checker)
  logic wr_acc, rd_acc, wr_part;
  logic [NCORES-1:0][DW-1:0] vec_lo, vec_hi;
  logic [NCORES-1:0]         pwr_req;

  cc_bus_qual #(.BE_W(4)) u_qual (
    .bus_wr (bus_wr),
    .bus_rd (bus_rd),
    .bus_be (bus_be),
    .wr_acc (wr_acc),
    .rd_acc (rd_acc),
    .wr_part(wr_part)
  );

  cc_regfile #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_acc (wr_acc),
    .rd_acc (rd_acc),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .vec_lo (vec_lo),
    .vec_hi (vec_hi),
    .pwr_req(pwr_req)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    cc_core_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .wfi_lvl  (wfi_in[g]),
      .pdn_req  (pwr_req[g]),
      .wfi_gated(wfi_out[g])
    );
    always_comb rst_vec_o[64*g +: 64] = join_vec(vec_hi[g], vec_lo[g]);
  end

  always_comb pwr_stat_o = pwr_req;
endmodule

// File: rtl/cc_chk.sv
module cc_chk
  import cc_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_acc,
  input logic                 rd_acc,
  input logic                 wr_part,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic [NCORES-1:0]    wfi_in,
  input logic [NCORES-1:0]    wfi_out,
  input logic [NCORES-1:0]    pwr,
  input logic [NCORES*64-1:0] vec
);
  logic              seen_edge;
  logic [NCORES-1:0] wfi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_edge <= 1'b0;
      wfi_prev  <= '0;
    end else begin
      seen_edge <= 1'b1;
      wfi_prev  <= wfi_in;
    end
  end

  // R5
  wfi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> (wfi_out == (pwr & wfi_prev)));

  // R4
  pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && addr == ADDR_W'(OFF_PCTL)) |=> (pwr == $past(wdata[NCORES-1:0])));

  // R6
  part_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_part |=> ($stable(vec) && $stable(pwr)));

  // R9
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> (rdata == 32'd0));

  for (genvar g = 0; g < NCORES; g++) begin : g_vchk
    // R3
    vec_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && addr == ADDR_W'(vec_off(g, 1'b0))) |=> (vec[64*g +: 32] == $past(wdata)));
    // R3
    vec_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && addr == ADDR_W'(vec_off(g, 1'b1))) |=> (vec[64*g+32 +: 32] == $past(wdata)));
  end
endmodule

bind core_cluster_ctrl cc_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_acc (wr_acc),
  .rd_acc (rd_acc),
  .wr_part(wr_part),
  .addr   (bus_addr),
  .wdata  (bus_wdata),
  .rdata  (bus_rdata),
  .wfi_in (wfi_in),
  .wfi_out(wfi_out),
  .pwr    (pwr_stat_o),
  .vec    (rst_vec_o)
);

// File: tb/core_cluster_ctrl_tb.sv
module core_cluster_ctrl_tb;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] wfi_in = '0, wfi_out, pwr_stat_o;
  logic [NC*64-1:0] rst_vec_o;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  core_cluster_ctrl u_dut (.*);

  // ---------------- reference model ----------------
  longint unsigned mreg[int];
  longint unsigned m_rd;
  logic [NC-1:0]   m_wfi;

  task automatic m_init();
    mreg.delete();
    mreg[24] = 32'h0F0F;  mreg[28] = 0;
    mreg[96] = 32'hF000F; mreg[128] = 0;
    mreg[144] = 0;        mreg[148] = 0;
    for (int i = 0; i < NC; i++) begin
      mreg[64 + 8*i] = 32'hFFFF0000;
      mreg[68 + 8*i] = 0;
    end
    m_rd  = 0;
    m_wfi = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_init();
    else begin
      longint unsigned nxt;
      int a;
      a = int'(bus_addr);
      nxt = 0;
      if (bus_rd && bus_be == 4'hF && mreg.exists(a)) nxt = mreg[a];
      if (bus_wr && bus_be == 4'hF && mreg.exists(a)) begin
        if (a == 144)      mreg[a] = bus_wdata & 32'h0000000F;
        else if (a == 148) mreg[a] = bus_wdata & ~32'h0003000F;
        else               mreg[a] = bus_wdata;
      end
      m_rd  = nxt;
      m_wfi = wfi_in;
    end
  end

  task automatic chk(string what, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      logic [NC-1:0] epwr;
      epwr = NC'(mreg[144]);
      chk("rdata", bus_rdata, m_rd);
      chk("pwr_stat", pwr_stat_o, epwr);
      chk("wfi_out", wfi_out, epwr & m_wfi);
      for (int i = 0; i < NC; i++)
        chk($sformatf("vec%0d", i), rst_vec_o[64*i +: 64],
            mreg[68 + 8*i] * 64'h1_0000_0000 + mreg[64 + 8*i]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n = 1);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; bus_be = 4'h0;
    end
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = 8'(a); bus_wdata = d; bus_be = be;
  endtask

  task automatic rd(int a, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_addr = 8'(a); bus_be = be;
  endtask

  task automatic rd_all();
    foreach (mreg[k]) rd(k);
    rd(0); rd(8'h24); rd(8'h64); rd(8'h98); rd(8'hFC);
    idle(1);
  endtask

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    rd_all();

    // R2 plain words
    cur_req = "R2";
    wr(24, 32'hA5A5_5A5A); wr(28, 32'hFFFF_FFFF); wr(96, 32'h1234_5678); wr(128, 32'h8000_0001);
    rd(24); rd(28); rd(96); rd(128); idle(1);

    // R3 boot words
    cur_req = "R3";
    for (int i = 0; i < NC; i++) begin
      wr(64 + 8*i, 32'h1000_0000 * (i + 1) + 32'h40);
      idle(1);
      wr(68 + 8*i, 32'hC0DE_0000 + i);
    end
    wr(68, 32'hFFFF_FFFF); wr(64, 32'h0);
    for (int i = 0; i < NC; i++) begin rd(64 + 8*i); rd(68 + 8*i); end
    idle(1);

    // R4 power-down request bits
    cur_req = "R4";
    wr(144, 32'h5); idle(1); wr(144, 32'hA); wr(144, 32'hA); wr(144, 32'h0); rd(144); idle(1);

    // R5 WFI gating
    cur_req = "R5";
    @(negedge clk) wfi_in = 4'hF;
    idle(2);
    wr(144, 32'h3); idle(2);
    @(negedge clk) wfi_in = 4'h6;
    idle(2);
    wr(144, 32'hF);
    @(negedge clk) wfi_in = 4'h9;
    idle(1);
    @(negedge clk) wfi_in = 4'h0;
    idle(2);

    // R10 upper power-control bits
    cur_req = "R10";
    wr(144, 32'hFFFF_FFF0); rd(144); wr(144, 32'hFFFF_FFFF); rd(144); idle(1);

    // R6 partial strobes
    cur_req = "R6";
    wr(64, 32'hDEAD_BEEF, 4'h7); wr(144, 32'h0, 4'hE); wr(24, 32'h0, 4'h0);
    rd(24, 4'h1); rd(64, 4'hE); rd(24); rd(64); rd(144); idle(1);

    // R7 status word read-only mask
    cur_req = "R7";
    wr(148, 32'hFFFF_FFFF); rd(148); wr(148, 32'h0003_000F); rd(148); idle(1);

    // R8 unmapped offsets
    cur_req = "R8";
    wr(0, 32'hFFFF_FFFF); wr(8'h24, 32'h1); wr(8'h64, 32'h2); wr(8'h98, 32'h3); wr(8'hFC, 32'h4);
    wr(8'h42, 32'h5);
    rd_all();

    // R9 same-cycle read and write
    cur_req = "R9";
    @(negedge clk);
    bus_wr = 1; bus_rd = 1; bus_addr = 8'd28; bus_wdata = 32'h0BAD_F00D; bus_be = 4'hF;
    rd(28); idle(2);

    // R11 reset in mid-run with live WFI and requests
    cur_req = "R11";
    wr(144, 32'hF);
    @(negedge clk) wfi_in = 4'hF;
    idle(2);
    @(negedge clk) rst_n = 1'b0;
    idle(2);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    wfi_in = 4'h0;
    rd_all();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule